// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block is the digital controller inside a battery-charging safety switch. It reads comparator decisions that have already been turned into logic levels (supply-good, input overvoltage, battery overvoltage, overcurrent, and a high/low pair of temperature flags) together with an active-low enable. From them it drives the pass-switch enable, a soft-start ramp request, a "fully on" indication and an active-low fault flag.

After supply-good rises, the controller waits out a settling delay and then runs a counted soft-start interval. Each fault class gets its own response. Input overvoltage cuts the switch at once and restarts through the full delay. Battery overvoltage and overcurrent must persist for a blanking window before they act. After such a trip the controller restarts through soft-start only, and it counts these trips so that the sixteenth one of a class locks the switch off. Over-temperature uses a high/low hysteresis pair. Every delay is a parameter in clock cycles, and every input passes through a two-flop synchronizer.

Top module: `chg_guard_seq`

## Requirements
- R1: While supply-good is low the switch is off. After it rises, the switch stays off for at least DELAY_CYC cycles and then enters soft-start.
- R2: An input-overvoltage level turns `sw_on_o` off no later than the second rising edge after it is applied. Once it clears, the switch stays off for at least DELAY_CYC cycles before soft-start begins again.
- R3: If input overvoltage is present before the power-up delay ends, the switch is not enabled for as long as it stays present.
- R4: A battery-overvoltage level shorter than BLANK_CYC cycles has no effect. One held for longer turns the switch off. When it clears, soft-start restarts without the DELAY_CYC wait.
- R5: An overcurrent level follows the same blanking and the same restart rule as R4.
- R6: Battery-overvoltage trips are counted in a CNT_W-bit counter (4 bits gives 16). The trip that finds the counter full latches the switch off. Only supply-good falling clears this latch; toggling the enable does not.
- R7: Overcurrent trips are counted in their own CNT_W-bit counter with the same latch rule. This latch and its counter clear when supply-good falls or when the enable is driven high.
- R8: Soft-start lasts RAMP_CYC cycles with `ramp_req_o` high. `full_on_o` rises only when that interval completes, and a fault during the ramp aborts it.
- R9: The over-temperature-high flag turns the switch off. Operation resumes, through the full delay, only after the over-temperature-low flag has been seen.
- R10: The enable is active low: high holds the switch off, and low lets it power up through the delay.
- R11: `fault_n_o` is low while input overvoltage or over-temperature is in effect, while waiting after a blanked trip, and while latched off. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Supply-good comparator flag |
| in_ovp_i | input | 1 | Input overvoltage flag |
| bat_ovp_i | input | 1 | Battery overvoltage flag |
| ocp_i | input | 1 | Overcurrent flag |
| ot_hi_i | input | 1 | Die temperature above the upper trip point |
| ot_lo_i | input | 1 | Die temperature below the lower release point |
| en_n_i | input | 1 | Active-low enable |
| sw_on_o | output | 1 | Pass-switch enable |
| ramp_req_o | output | 1 | Soft-start ramp in progress |
| full_on_o | output | 1 | Soft-start complete, switch fully on |
| fault_n_o | output | 1 | Active-low protection flag |

## Verification
The two blanking filters can expire on the same clock edge, and both trip counters must then advance on that edge. The bench provokes this by raising the battery-overvoltage and overcurrent flags on the same edge and holding both past the blanking window, fifteen times in a row. It judges the result by what happens next. A single further overcurrent-only trip must latch the switch off. After the enable is toggled, a single battery-only trip must latch it again. Only a counter that missed one of the simultaneous trips would need extra events.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_ON    = 3'd3,
    ST_HOLD  = 3'd4,
    ST_LATCH = 3'd5
  } gate_st_e;

  // True on the last cycle of an interval of lim cycles counted from zero.
  function automatic logic last_tick(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

  // Larger of two interval lengths, used to size a shared timer.
  function automatic int max_len(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cg_sync2.sv
module cg_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cg_blank.sv
module cg_blank
  import chg_guard_pkg::*;
#(
  parameter int BLANK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic flag_i,
  output logic evt_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          evt;

  assign evt = arm_i && flag_i && last_tick(32'(cnt_q), 32'(BLANK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (arm_i && flag_i)  cnt_q <= evt ? '0 : cnt_q + CW'(1);
    else                       cnt_q <= '0;
  end

  assign evt_o = evt;

  // R4 / R5: a trip needs the flag present on this and the previous cycle (BLANK_CYC >= 2)
  assert_blank_persist_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (flag_i && $past(flag_i)));
endmodule

// File: rtl/cg_evt_cnt.sv
module cg_evt_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic evt_i,
  output logic trip_o,
  output logic latch_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             latch_q;
  logic             full;

  assign full   = &cnt_q;
  assign trip_o = evt_i && full && !latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else if (evt_i && !latch_q) begin
      if (full) latch_q <= 1'b1;
      else      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign latch_o = latch_q;

  // R6 (and R7): once set, the latch holds until its clear arrives
  assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr_i) |=> latch_q);
endmodule

// File: rtl/chg_guard_seq.sv
module chg_guard_seq
  import chg_guard_pkg::*;
#(
  parameter int DELAY_CYC = 200,
  parameter int BLANK_CYC = 40,
  parameter int RAMP_CYC  = 30,
  parameter int CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok_i,
  input  logic in_ovp_i,
  input  logic bat_ovp_i,
  input  logic ocp_i,
  input  logic ot_hi_i,
  input  logic ot_lo_i,
  input  logic en_n_i,
  output logic sw_on_o,
  output logic ramp_req_o,
  output logic full_on_o,
  output logic fault_n_o
);
  localparam int NIN  = 7;
  localparam int TMAX = max_len(DELAY_CYC, RAMP_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  // synchronized flags
  logic [NIN-1:0] raw_in, sync_out;
  logic por_s, ovp_s, bat_s, ocp_s, othi_s, otlo_s, en_n_s;

  assign raw_in = {en_n_i, ot_lo_i, ot_hi_i, ocp_i, bat_ovp_i, in_ovp_i, por_ok_i};

  cg_sync2 #(.W(NIN), .RST_VAL(7'b100_0000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  assign {en_n_s, otlo_s, othi_s, ocp_s, bat_s, ovp_s, por_s} = sync_out;

  // state
  gate_st_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          ot_q;

  // named internal events
  logic sw_live, bat_evt, ocp_evt, slow_evt;
  logic bat_trip, ocp_trip, bat_latch, ocp_latch, trip_now, latched;
  logic bat_clr, ocp_clr;

  assign sw_live = (st_q == ST_RAMP) || (st_q == ST_ON);

  cg_blank #(.BLANK_CYC(BLANK_CYC)) u_blank_bat (
    .clk(clk), .rst_n(rst_n), .arm_i(sw_live), .flag_i(bat_s), .evt_o(bat_evt)
  );

  cg_blank #(.BLANK_CYC(BLANK_CYC)) u_blank_ocp (
    .clk(clk), .rst_n(rst_n), .arm_i(sw_live), .flag_i(ocp_s), .evt_o(ocp_evt)
  );

  assign bat_clr = !por_s;
  assign ocp_clr = !por_s || en_n_s;

  cg_evt_cnt #(.CNT_W(CNT_W)) u_cnt_bat (
    .clk(clk), .rst_n(rst_n), .clr_i(bat_clr), .evt_i(bat_evt),
    .trip_o(bat_trip), .latch_o(bat_latch)
  );

  cg_evt_cnt #(.CNT_W(CNT_W)) u_cnt_ocp (
    .clk(clk), .rst_n(rst_n), .clr_i(ocp_clr), .evt_i(ocp_evt),
    .trip_o(ocp_trip), .latch_o(ocp_latch)
  );

  assign slow_evt = bat_evt || ocp_evt;
  assign trip_now = bat_trip || ocp_trip;
  assign latched  = bat_latch || ocp_latch;

  // over-temperature hysteresis flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ot_q <= 1'b0;
    else if (!por_s)          ot_q <= 1'b0;
    else if (othi_s)          ot_q <= 1'b1;
    else if (otlo_s)          ot_q <= 1'b0;
  end

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (!por_s || en_n_s) begin
      st_d  = ST_OFF;
      tmr_d = '0;
    end else if (latched || trip_now) begin
      st_d  = ST_LATCH;
      tmr_d = '0;
    end else if (ovp_s || ot_q) begin
      st_d  = ST_WAIT;
      tmr_d = '0;
    end else begin
      case (st_q)
        ST_OFF, ST_LATCH: begin
          st_d  = ST_WAIT;
          tmr_d = '0;
        end
        ST_WAIT: begin
          if (last_tick(32'(tmr_q), 32'(DELAY_CYC))) begin
            st_d  = ST_RAMP;
            tmr_d = '0;
          end else begin
            tmr_d = tmr_q + TW'(1);
          end
        end
        ST_RAMP: begin
          if (slow_evt) begin
            st_d  = ST_HOLD;
            tmr_d = '0;
          end else if (last_tick(32'(tmr_q), 32'(RAMP_CYC))) begin
            st_d  = ST_ON;
            tmr_d = '0;
          end else begin
            tmr_d = tmr_q + TW'(1);
          end
        end
        ST_ON: begin
          if (slow_evt) begin
            st_d  = ST_HOLD;
            tmr_d = '0;
          end
        end
        ST_HOLD: begin
          if (!bat_s && !ocp_s) begin
            st_d  = ST_RAMP;
            tmr_d = '0;
          end
        end
        default: begin
          st_d  = ST_OFF;
          tmr_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  // outputs: input overvoltage gates the switch directly for the fast path
  assign sw_on_o    = sw_live && !ovp_s;
  assign ramp_req_o = (st_q == ST_RAMP) && !ovp_s;
  assign full_on_o  = (st_q == ST_ON) && !ovp_s;
  assign fault_n_o  = !(ovp_s || ot_q || (st_q == ST_HOLD) || (st_q == ST_LATCH));

  // R1: supply-good low for two cycles means the switch is off
  assert_off_without_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_s && $past(!por_s)) |-> !sw_on_o);

  // R2: a persisting input overvoltage pins the sequencer before soft-start
  assert_ovp_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_s && $past(ovp_s)) |-> !sw_live);

  // R7 (and R6): a set trip latch keeps the switch off
  assert_latch_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> !sw_on_o);

  // R8: fully-on is entered only from the ramp
  assert_ramp_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_on_o) |-> $past(st_q == ST_RAMP));

  // R9: over-temperature held for two cycles means the switch is off
  assert_ot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && $past(ot_q)) |-> !sw_on_o);
endmodule

// File: tb/test_chg_guard_seq.sv
module test_chg_guard_seq;
  localparam int DL = 200;
  localparam int BL = 40;
  localparam int RP = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok_i = 1'b0, in_ovp_i = 1'b0, bat_ovp_i = 1'b0, ocp_i = 1'b0;
  logic ot_hi_i = 1'b0, ot_lo_i = 1'b0, en_n_i = 1'b0;
  logic sw_on_o, ramp_req_o, full_on_o, fault_n_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chg_guard_seq #(.DELAY_CYC(DL), .BLANK_CYC(BL), .RAMP_CYC(RP), .CNT_W(4)) i_chg_guard_seq (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por_ok_i), .in_ovp_i(in_ovp_i),
    .bat_ovp_i(bat_ovp_i), .ocp_i(ocp_i), .ot_hi_i(ot_hi_i), .ot_lo_i(ot_lo_i),
    .en_n_i(en_n_i), .sw_on_o(sw_on_o), .ramp_req_o(ramp_req_o),
    .full_on_o(full_on_o), .fault_n_o(fault_n_o)
  );

  typedef struct packed {
    logic       use_bat;
    logic [7:0] len;
    logic       trip;
  } vec_t;

  // blanking table: flag, held cycles, whether it must trip
  localparam vec_t VEC [4] = '{
    '{1'b1, 8'(BL - 3), 1'b0},
    '{1'b1, 8'(BL + 6), 1'b1},
    '{1'b0, 8'(BL - 3), 1'b0},
    '{1'b0, 8'(BL + 6), 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic power_cycle();
    por_ok_i = 1'b0;
    tick(5);
    por_ok_i = 1'b1;
    tick(DL + RP + 10);
  endtask

  task automatic pulse(input logic b, input logic o, input int n);
    bat_ovp_i = b;
    ocp_i     = o;
    tick(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk(sw_on_o, 1'b0, "R1 reset sw_on");
    chk(fault_n_o, 1'b1, "R11 reset fault_n");
    chk(ramp_req_o, 1'b0, "R8 reset ramp_req");
    rst_n = 1'b1;
    tick(3);

    // R1 power-up delay then R8 ramp
    por_ok_i = 1'b1;
    tick(DL + 1);
    chk(sw_on_o, 1'b0, "R1 off during delay");
    tick(4);
    chk(sw_on_o, 1'b1, "R1 on after delay");
    chk(ramp_req_o, 1'b1, "R8 ramp after delay");
    chk(full_on_o, 1'b0, "R8 not full during ramp");
    tick(RP);
    chk(full_on_o, 1'b1, "R8 full after ramp");
    chk(ramp_req_o, 1'b0, "R8 ramp ends");

    // blanking table (R4, R5)
    for (int i = 0; i < 4; i++) begin
      pulse(VEC[i].use_bat, !VEC[i].use_bat, int'(VEC[i].len));
      chk(sw_on_o, !VEC[i].trip, VEC[i].use_bat ? "R4 blank sw_on" : "R5 blank sw_on");
      chk(fault_n_o, !VEC[i].trip, "R11 blank fault_n");
      pulse(1'b0, 1'b0, RP + 10);
      chk(full_on_o, 1'b1, VEC[i].use_bat ? "R4 restart no delay" : "R5 restart no delay");
    end

    // R2 input overvoltage fast path and full-delay restart
    in_ovp_i = 1'b1;
    tick(2);
    chk(sw_on_o, 1'b0, "R2 fast shutoff");
    chk(fault_n_o, 1'b0, "R11 ovp fault_n");
    in_ovp_i = 1'b0;
    tick(DL - 2);
    chk(sw_on_o, 1'b0, "R2 delay after ovp");
    tick(10);
    chk(sw_on_o, 1'b1, "R2 restart after delay");
    tick(RP);

    // R3 overvoltage during power-up delay
    por_ok_i = 1'b0;
    tick(5);
    por_ok_i = 1'b1;
    tick(50);
    in_ovp_i = 1'b1;
    tick(DL + RP + 20);
    chk(sw_on_o, 1'b0, "R3 never enabled");
    chk(full_on_o, 1'b0, "R3 never full");
    in_ovp_i = 1'b0;
    tick(DL + RP + 10);
    chk(full_on_o, 1'b1, "R3 powers up after clear");

    // R8 abort by over-temperature, R9 hysteresis
    en_n_i = 1'b1;
    tick(5);
    chk(sw_on_o, 1'b0, "R10 disable high");
    en_n_i = 1'b0;
    tick(DL + 10);
    chk(ramp_req_o, 1'b1, "R10 enable low ramps");
    ot_hi_i = 1'b1;
    tick(4);
    chk(sw_on_o, 1'b0, "R9 ot_hi off");
    chk(ramp_req_o, 1'b0, "R8 ramp aborted");
    ot_hi_i = 1'b0;
    tick(DL + RP + 20);
    chk(sw_on_o, 1'b0, "R9 waits for ot_lo");
    chk(fault_n_o, 1'b0, "R11 ot fault_n");
    ot_lo_i = 1'b1;
    tick(3);
    ot_lo_i = 1'b0;
    tick(DL + RP + 10);
    chk(full_on_o, 1'b1, "R9 resumes after ot_lo");

    // clear counters, then simultaneous trips
    power_cycle();
    chk(full_on_o, 1'b1, "R6 clean start");
    for (int k = 0; k < 15; k++) begin
      pulse(1'b1, 1'b1, BL + 6);
      chk(sw_on_o, 1'b0, "R4 joint trip");
      pulse(1'b0, 1'b0, RP + 10);
      chk(full_on_o, 1'b1, "R5 joint restart");
    end
    pulse(1'b0, 1'b1, BL + 6);
    pulse(1'b0, 1'b0, DL + RP + 20);
    chk(sw_on_o, 1'b0, "R7 ocp latched on 16th");
    chk(fault_n_o, 1'b0, "R11 latch fault_n");
    en_n_i = 1'b1;
    tick(5);
    en_n_i = 1'b0;
    tick(DL + RP + 10);
    chk(full_on_o, 1'b1, "R7 enable toggle clears");
    pulse(1'b1, 1'b0, BL + 6);
    pulse(1'b0, 1'b0, DL + RP + 20);
    chk(sw_on_o, 1'b0, "R6 bat latched on 16th");
    en_n_i = 1'b1;
    tick(5);
    en_n_i = 1'b0;
    tick(DL + RP + 10);
    chk(sw_on_o, 1'b0, "R6 enable toggle no clear");
    power_cycle();
    chk(full_on_o, 1'b1, "R6 power cycle clears");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule